// File: doc/BRIEF.md
# Chaotic Sample Bit Extractor

This block is the digital back end of a random bit source built from three chaotic oscillators. An external multiplexer picks one oscillator at a time, and a 4-bit converter digitizes the picked voltage. The block drives the multiplexer select in a fixed rotation. It also drives three one-hot phase enables, one per oscillator, so that each oscillator is active in exactly one cycle out of three.

On every enabled clock edge, the block keeps only the least significant bit of the converted code. It pushes that bit into a three-deep bit history. Its output bit is the parity of the whole history. Once three bits have entered since reset, a fresh output bit that depends on all three sources is ready on every enabled cycle.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block stays in its reset state for two further rising edges after the input goes high.

Top module: `chaos_bit_extractor`

## Requirements
- R1: After reset `sel_o` is 0. On every rising edge with `en_i` high it steps 0 → 1 → 2 → 0.
- R2: `phase_en_o` has exactly one bit set, and bit k is set exactly when `sel_o` equals k. While enabled, the set bit rotates upward by one position each cycle (bit 2 wraps to bit 0).
- R3: On a rising edge with `en_i` high, bit 0 of `code_i` is captured as the newest history bit. This sample belongs to the source selected during the cycle that this edge ends. Bits 3..1 of `code_i` have no effect on any output.
- R4: `rand_o` is the XOR of the three history bits. With `en_i` held high it carries a bit that includes the newest sample after every edge.
- R5: While reset is applied: `sel_o` = 0, `phase_en_o` = 3'b001, `rand_o` = 0 and `rand_vld_o` = 0. Asserting `rst_n` clears the outputs at once, without a clock edge.
- R6: `rand_vld_o` goes high on the third enabled edge after reset, counting only edges with `en_i` high. It then stays high until the next reset.
- R7: With `en_i` low, the select, the bit history (and thus `rand_o`) and `rand_vld_o` keep their values across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| en_i | input | 1 | Advance enable for rotation, capture and fill counting |
| code_i | input | 4 | Converter code of the currently selected source |
| sel_o | output | 2 | Multiplexer select, 0..2 |
| phase_en_o | output | 3 | One-hot per-source phase enables |
| rand_o | output | 1 | Parity of the three most recent kept bits |
| rand_vld_o | output | 1 | High once three bits have been captured since reset |

## Verification
Two functions can land on the same edge. The first is the rise of `rand_vld_o`, which comes on the third enabled capture. The second is the select wrapping from 2 back to 0, since the third capture is also the capture at select 2. The bench provokes this right after reset, and again after a second reset in which `en_i` is dropped for a few cycles before the third capture. That checks that the flag waits for the capture and not for the cycle count. At every edge, a model scoreboard compares the select, the phases, the parity bit and the flag together. A hold cycle that wrongly advanced either the rotation or the fill count would show up as a mismatch in the same comparison.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  function automatic logic pick_bit(input logic [31:0] word, input int unsigned idx);
    return word[idx];
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/cbx_rst_sync.sv
module cbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbx_phase_rotor.sv
module cbx_phase_rotor #(
  parameter int unsigned N_SRC = 3,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [N_SRC-1:0] phase_o
);
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (adv_i) sel_d = SEL_W'(cbx_pkg::wrap_inc(int'(sel_q), N_SRC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_phase
    assign phase_o[k] = (sel_q == SEL_W'(k));
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/cbx_lsb_history.sv
module cbx_lsb_history #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_i,
  input  logic bit_i,
  output logic parity_o
);
  logic [DEPTH-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_i) hist_d = {hist_q[DEPTH-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign parity_o = ^hist_q;
endmodule

// File: rtl/cbx_fill_tracker.sv
module cbx_fill_tracker #(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic full_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign full = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full_o = full;
endmodule

// File: rtl/chaos_bit_extractor.sv
module chaos_bit_extractor #(
  parameter int unsigned N_SRC       = 3,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned TAP_BIT     = 0,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [N_SRC-1:0]  phase_en_o,
  output logic              rand_o,
  output logic              rand_vld_o
);
  logic rst_int_n;
  logic kept_bit;

  assign kept_bit = cbx_pkg::pick_bit(32'(code_i), TAP_BIT);

  cbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  cbx_phase_rotor #(.N_SRC(N_SRC)) u_rotor (
    .clk(clk), .rst_n(rst_int_n), .adv_i(en_i),
    .sel_o(sel_o), .phase_o(phase_en_o)
  );

  cbx_lsb_history #(.DEPTH(N_SRC)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .shift_i(en_i),
    .bit_i(kept_bit), .parity_o(rand_o)
  );

  cbx_fill_tracker #(.DEPTH(N_SRC)) u_fill (
    .clk(clk), .rst_n(rst_int_n), .adv_i(en_i), .full_o(rand_vld_o)
  );
endmodule

// File: rtl/cbx_checker.sv
module cbx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       lsb_i,
  input logic [1:0] sel_o,
  input logic [2:0] phase_en_o,
  input logic       rand_o,
  input logic       rand_vld_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != 2'd3); // R1
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> sel_o == (($past(sel_o) == 2'd2) ? 2'd0 : $past(sel_o) + 2'd1)); // R1
  AST_PHASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_en_o) == 1); // R2
  AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> phase_en_o == {$past(phase_en_o[1:0]), $past(phase_en_o[2])}); // R2
  AST_PARITY_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) && en_i && $past(en_i) && $past(en_i, 2)
    |=> rand_o == ($past(lsb_i) ^ $past(lsb_i, 2) ^ $past(lsb_i, 3))); // R4
  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rand_vld_o |=> rand_vld_o); // R6
  AST_VLD_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !rand_vld_o && !en_i |=> !rand_vld_o); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(sel_o) && $stable(rand_o) && $stable(rand_vld_o)); // R7
endmodule

bind chaos_bit_extractor cbx_checker u_cbx_checker (
  .clk(clk), .rst_n(rst_int_n), .en_i(en_i), .lsb_i(code_i[0]),
  .sel_o(sel_o), .phase_en_o(phase_en_o), .rand_o(rand_o), .rand_vld_o(rand_vld_o)
);

// File: tb/chaos_bit_extractor_tb_top.sv
module chaos_bit_extractor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] code;
  logic [1:0] sel;
  logic [2:0] phase;
  logic       rnd, vld;

  always #5 clk = ~clk;

  chaos_bit_extractor dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .code_i(code),
    .sel_o(sel), .phase_en_o(phase), .rand_o(rnd), .rand_vld_o(vld)
  );

  typedef struct {
    logic [1:0] sel;
    logic [2:0] ph;
    logic       rnd;
    logic       vld;
    logic       en;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int m_sel  = 0;
  int m_cnt  = 0;
  logic [2:0] m_hist = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_cnt = 0; m_hist = '0;
  endtask

  task automatic drive(input logic e, input logic [3:0] c);
    exp_t x;
    @(negedge clk);
    en = e; code = c;
    if (e) begin
      m_hist = {m_hist[1:0], c[0]};
      m_sel  = (m_sel + 1) % 3;
      if (m_cnt < 3) m_cnt++;
    end
    x.sel = 2'(m_sel); x.ph = 3'(1 << m_sel); x.rnd = ^m_hist;
    x.vld = (m_cnt == 3); x.en = e;
    q.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(sel == x.sel, x.en ? "R1 select" : "R7 select hold", sel, x.sel);
        chk(phase == x.ph, "R2 phase", phase, x.ph);
        chk(rnd == x.rnd, x.en ? "R3 R4 parity" : "R7 parity hold", rnd, x.rnd);
        chk(vld == x.vld, x.en ? "R6 valid" : "R7 valid hold", vld, x.vld);
      end
    end
  end

  task automatic check_reset_state();
    chk(sel == 2'd0, "R5 reset select", sel, 0);
    chk(phase == 3'b001, "R5 reset phase", phase, 1);
    chk(rnd == 1'b0, "R5 reset parity", rnd, 0);
    chk(vld == 1'b0, "R5 reset valid", vld, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; code = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #2 check_reset_state();
    @(negedge clk) rst_n = 1'b1;
    repeat (4) drive(1'b0, 4'h0);
    // first fill: valid rises together with the wrap 2->0 (R6 R1)
    drive(1'b1, 4'b1011);
    drive(1'b1, 4'b0100);
    drive(1'b1, 4'b1111);
    drive(1'b1, 4'b0000);
    // upper bits toggle, LSB fixed: parity follows LSB only (R3)
    for (int i = 0; i < 6; i++) drive(1'b1, {3'(i * 5 + 3), 1'b1});
    for (int i = 0; i < 6; i++) drive(1'b1, {3'(i * 3 + 1), 1'b0});
    // hold stretch with changing code (R7)
    for (int i = 0; i < 5; i++) drive(1'b0, 4'(i * 7 + 1));
    // mixed random traffic
    for (int i = 0; i < 120; i++) drive(1'(($urandom % 10) < 7), 4'($urandom));
    @(posedge clk); #2;
    // asynchronous reset mid-run (R5)
    rst_n = 1'b0;
    #1 check_reset_state();
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) drive(1'b0, 4'h1);
    // valid must wait for the third capture, not the third cycle (R6)
    drive(1'b1, 4'h1);
    drive(1'b1, 4'h1);
    drive(1'b0, 4'h0);
    drive(1'b0, 4'h1);
    drive(1'b1, 4'h0);
    drive(1'b0, 4'h1);
    for (int i = 0; i < 40; i++) drive(1'b1, 4'($urandom));
    @(posedge clk); #2;
    finish_run();
  end
endmodule